// File: doc/BRIEF.md
# Boot Serial Flash Command Engine

This block is an SPI master that drives a serial boot flash through a small, fixed set of commands. These commands are enough to read, program and erase firmware images. A requester selects one of eight operations on a 3-bit code and supplies a 24-bit address, a byte count and write bytes. The engine then frames the command on the serial pins. It returns the bytes read from the flash one at a time on a valid strobe. It pulses `done` once the whole operation, including any internal housekeeping frames, has finished.

Frames use clock-idle-high timing (SPI mode 3) with 8-bit words sent most significant bit first. The engine handles program and erase operations on its own:

- It first sends a separate write-enable frame.
- It then sends the command.
- It then repeats status-read frames until the flash reports that it is no longer busy.

Chip select stays high for at least a programmable number of system clocks between any two frames. A page-program request with an illegal length is refused before any pin moves.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, and whenever chip select is high, the serial clock is high. `req_ready` is high after reset, and `done`, `err` and `rd_valid` are low.
- R2: Each frame byte is shifted most significant bit first. The master changes `spi_mosi` only while the clock is low or before the first falling edge. It samples `spi_miso` on each rising clock edge.
- R3: Operation code 0 sends the single byte 0x06, and code 1 sends the single byte 0x04. Each is a frame of exactly one byte.
- R4: Operation code 2 sends 0x05 followed by one dummy byte. The byte received during that dummy byte is returned on `rd_valid`/`rd_data`.
- R5: Operation code 3 sends 0x03, then the address as three bytes with the high byte first, then `req_len` dummy bytes. Every received data byte is returned in order. A length of 0 gives a 4-byte frame with no returned data.
- R6: Operation code 7 sends 0x9F followed by three dummy bytes, and returns the three received bytes in order.
- R7: Operation code 4 sends 0x02, the three address bytes and then `req_len` bytes taken from `wr_data`. Each byte is consumed in a cycle where `wr_take` is high, and a new byte is expected on `wr_data` after that cycle.
- R8: Operation code 5 sends 0x20 and three address bytes. Operation code 6 sends the single byte 0xC7.
- R9: Operation codes 4, 5 and 6 are preceded by a separate 0x06 frame. They are followed by 0x05 status frames, repeated while bit 0 of the returned status is 1. `done` pulses only after the first status frame that returns bit 0 as 0.
- R10: Between the end of one frame and the start of the next, chip select stays high for at least `cfg_gap` system clocks.
- R11: An operation code 4 request with `req_len` of 0 or above 256 pulses `err` for one cycle. It drives no frame and gives no `done`.
- R12: `req_ready` is high only while the engine is idle. Each accepted request that is not rejected produces exactly one `done` pulse, and `done` and `err` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gap | input | 8 | Minimum chip-select high time between frames, in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_op | input | 3 | Operation code (0 wren, 1 wrdi, 2 status, 3 read, 4 program, 5 sector erase, 6 chip erase, 7 identify) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 16 | Data byte count for read and program |
| wr_data | input | 8 | Current program byte |
| wr_take | output | 1 | Program byte on wr_data consumed this cycle |
| rd_valid | output | 1 | rd_data holds a received byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse at operation end |
| err | output | 1 | One-cycle pulse on rejected request |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that `rst_n` is held low before the first clock and that `spi_miso` settles within one system clock of a falling serial-clock edge. The bench's flash model drives it in the same time step as that edge. They also assume that `wr_data` holds the next program byte by the cycle after `wr_take`. The bench meets this by indexing its write pattern with a count of `wr_take` pulses. Requests are raised only while the engine is idle, and `cfg_gap` changes only between requests, so the gap checks never see a window that moves mid-frame.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_WREN   = 3'd0,
    OP_WRDI   = 3'd1,
    OP_RDSR   = 3'd2,
    OP_READ   = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_CERASE = 3'd6,
    OP_RDID   = 3'd7
  } flash_op_e;

  typedef enum logic [1:0] {
    FR_WREN = 2'd0,
    FR_MAIN = 2'd1,
    FR_POLL = 2'd2
  } frame_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GAP  = 2'd1,
    S_XFER = 2'd2
  } eng_state_e;

  localparam logic [7:0] CODE_WREN = 8'h06;
  localparam logic [7:0] CODE_RDSR = 8'h05;

  function automatic logic [7:0] op_code(flash_op_e op);
    case (op)
      OP_WREN:   return 8'h06;
      OP_WRDI:   return 8'h04;
      OP_RDSR:   return 8'h05;
      OP_READ:   return 8'h03;
      OP_PROG:   return 8'h02;
      OP_SERASE: return 8'h20;
      OP_CERASE: return 8'hC7;
      default:   return 8'h9F;
    endcase
  endfunction

  function automatic logic op_has_addr(flash_op_e op);
    return (op == OP_READ) || (op == OP_PROG) || (op == OP_SERASE);
  endfunction

  function automatic logic op_needs_wel(flash_op_e op);
    return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_CERASE);
  endfunction

  function automatic logic op_returns(flash_op_e op);
    return (op == OP_RDSR) || (op == OP_READ) || (op == OP_RDID);
  endfunction

endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
  parameter int HALF_PERIOD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF_PERIOD - 1);

  logic [HW-1:0] hcnt_q;
  logic [2:0]    bcnt_q;
  logic          first_q;
  logic [7:0]    tx_q, rx_q;

  assign mosi    = tx_q[7];
  assign rx_byte = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b1;
      hcnt_q  <= '0;
      bcnt_q  <= '0;
      first_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          tx_q    <= tx_byte;
          hcnt_q  <= '0;
          bcnt_q  <= '0;
          first_q <= 1'b1;
        end
      end else if (hcnt_q == HLAST) begin
        hcnt_q <= '0;
        if (sclk) begin
          sclk    <= 1'b0;
          first_q <= 1'b0;
          if (!first_q) tx_q <= {tx_q[6:0], 1'b0};
        end else begin
          sclk <= 1'b1;
          rx_q <= {rx_q[6:0], miso};
          if (bcnt_q == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 3'd1;
          end
        end
      end else begin
        hcnt_q <= hcnt_q + HW'(1);
      end
    end
  end

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  // R1
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

endmodule

// File: rtl/flash_cs_gap.sv
module flash_cs_gap #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             gap_ok
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (frame_end)       cnt_q <= cfg_gap;
    else if (cnt_q != '0)     cnt_q <= cnt_q - GAP_W'(1);
  end

  assign gap_ok = (cnt_q == '0);

  // R10
  gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cfg_gap != '0) |=> !gap_ok);

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int HALF_PERIOD = 2,
  parameter int GAP_W       = 8,
  parameter int LEN_W       = 16,
  parameter int PAGE_MAX    = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int IDX_W = LEN_W + 1;
  typedef logic [IDX_W-1:0] idx_t;

  function automatic idx_t data_start(flash_op_e op);
    return op_has_addr(op) ? idx_t'(4) : idx_t'(1);
  endfunction

  function automatic idx_t last_idx(frame_e fr, flash_op_e op, logic [LEN_W-1:0] len);
    if (fr == FR_WREN) return idx_t'(0);
    if (fr == FR_POLL) return idx_t'(1);
    case (op)
      OP_RDSR:          return idx_t'(1);
      OP_RDID:          return idx_t'(3);
      OP_SERASE:        return idx_t'(3);
      OP_READ, OP_PROG: return idx_t'(3) + idx_t'(len);
      default:          return idx_t'(0);
    endcase
  endfunction

  function automatic logic len_bad(logic [LEN_W-1:0] len);
    return (len == '0) || (32'(len) > 32'(PAGE_MAX));
  endfunction

  function automatic logic [7:0] byte_for(frame_e fr, flash_op_e op, idx_t i,
                                          logic [23:0] a, logic [7:0] wd);
    if (fr == FR_WREN) return CODE_WREN;
    if (fr == FR_POLL) return (i == '0) ? CODE_RDSR : 8'h00;
    if (i == '0) return op_code(op);
    if (op_has_addr(op) && i < idx_t'(4)) begin
      if (i == idx_t'(1)) return a[23:16];
      if (i == idx_t'(2)) return a[15:8];
      return a[7:0];
    end
    return (op == OP_PROG) ? wd : 8'h00;
  endfunction

  eng_state_e       state_q;
  frame_e           frame_q;
  flash_op_e        op_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  idx_t             bidx_q;
  logic             cs_n_q, done_q, err_q, rdv_q;
  logic [7:0]       rdd_q;

  logic       sh_done, sh_busy, gap_ok;
  logic [7:0] sh_rx, tx_byte;
  logic       is_last, frame_end, launch, rx_is_data;
  idx_t       launch_idx;

  assign is_last    = (bidx_q == last_idx(frame_q, op_q, len_q));
  assign frame_end  = (state_q == S_XFER) && sh_done && is_last;
  assign launch     = ((state_q == S_GAP) && gap_ok) ||
                      ((state_q == S_XFER) && sh_done && !is_last);
  assign launch_idx = (state_q == S_GAP) ? '0 : bidx_q + idx_t'(1);
  assign tx_byte    = byte_for(frame_q, op_q, launch_idx, addr_q, wr_data);
  assign wr_take    = launch && (frame_q == FR_MAIN) && (op_q == OP_PROG) &&
                      (launch_idx >= idx_t'(4));
  assign rx_is_data = (frame_q == FR_MAIN) && op_returns(op_q) &&
                      (bidx_q >= data_start(op_q));

  flash_spi_shifter #(.HALF_PERIOD(HALF_PERIOD)) shifter_i (
    .clk(clk), .rst_n(rst_n), .start(launch), .tx_byte(tx_byte),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy),
    .done(sh_done), .rx_byte(sh_rx)
  );

  flash_cs_gap #(.GAP_W(GAP_W)) gap_i (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cfg_gap(cfg_gap),
    .gap_ok(gap_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      frame_q <= FR_MAIN;
      op_q    <= OP_WREN;
      addr_q  <= '0;
      len_q   <= '0;
      bidx_q  <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            if (flash_op_e'(req_op) == OP_PROG && len_bad(req_len)) begin
              err_q <= 1'b1;
            end else begin
              op_q    <= flash_op_e'(req_op);
              addr_q  <= req_addr;
              len_q   <= req_len;
              frame_q <= op_needs_wel(flash_op_e'(req_op)) ? FR_WREN : FR_MAIN;
              state_q <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gap_ok) begin
            cs_n_q  <= 1'b0;
            bidx_q  <= '0;
            state_q <= S_XFER;
          end
        end
        default: begin
          if (sh_done) begin
            if (rx_is_data) begin
              rdv_q <= 1'b1;
              rdd_q <= sh_rx;
            end
            if (is_last) begin
              cs_n_q <= 1'b1;
              case (frame_q)
                FR_WREN: begin
                  frame_q <= FR_MAIN;
                  state_q <= S_GAP;
                end
                FR_MAIN: begin
                  if (op_needs_wel(op_q)) begin
                    frame_q <= FR_POLL;
                    state_q <= S_GAP;
                  end else begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                  end
                end
                default: begin
                  if (sh_rx[0]) begin
                    state_q <= S_GAP;
                  end else begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                  end
                end
              endcase
            end else begin
              bidx_q <= launch_idx;
            end
          end
        end
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign spi_cs_n  = cs_n_q;
  assign done      = done_q;
  assign err       = err_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R10
  gap_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(gap_ok));

  // R11
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (spi_cs_n && !sh_busy));

  // R7
  take_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !spi_cs_n);

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  // R4
  rd_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sh_done));

endmodule

// File: tb/flash_cmd_engine_tb_top.sv
module flash_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_gap = 8'd5;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [7:0]  wr_data;
  logic        wr_take, rd_valid, done, err;
  logic [7:0]  rd_data;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] wpat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] idb(int k);
    return (k == 1) ? 8'hA1 : (k == 2) ? 8'hB2 : 8'hC3;
  endfunction

  // ---------------- flash model ----------------
  localparam int POLLS = 2;
  int bitr = 0, bitf = 0, nbytes = 0, busy_left = 0;
  logic wel = 1'b0;
  logic [7:0]  shin = '0, cur_op = '0;
  logic [23:0] cur_addr = '0;
  int frames = 0;
  logic [7:0]  fr_op [0:63];
  int          fr_nb [0:63];
  int          fr_gap[0:63];
  logic [23:0] fr_addr[0:63];
  logic [7:0]  pbuf[0:599];
  int pcount = 0, hi_run = 0, mode_viol = 0, idle_viol = 0;
  logic [7:0] rbuf[0:63];
  int rcount = 0, ndone = 0, takes = 0, wbase = 0;

  assign wr_data = wpat(takes - wbase);
  always @(posedge clk) if (wr_take) takes <= takes + 1;

  function automatic logic [7:0] resp(int k);
    if (k == 0) return 8'h00;
    case (cur_op)
      8'h05: return {6'b0, wel, busy_left > 0};
      8'h9F: return (k <= 3) ? idb(k) : 8'h00;
      8'h03: return (k >= 4) ? rpat(cur_addr + 24'(k - 4)) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge spi_cs_n) begin
    bitr = 0; bitf = 0; nbytes = 0;
    if (!spi_sclk) mode_viol++;
    if (frames < 64) fr_gap[frames] = hi_run;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    bitr++;
    if (bitr % 8 == 0) begin
      if (nbytes == 0) cur_op = shin;
      else if (nbytes <= 3) cur_addr = {cur_addr[15:0], shin};
      else if (cur_op == 8'h02 && pcount < 600) begin
        pbuf[pcount] = shin; pcount++;
      end
      nbytes++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] r;
    r = resp(bitf / 8);
    spi_miso = r[7 - (bitf % 8)];
    bitf++;
  end

  always @(posedge spi_cs_n) if (nbytes > 0) begin
    if (frames < 64) begin
      fr_op[frames] = cur_op; fr_nb[frames] = nbytes; fr_addr[frames] = cur_addr;
    end
    frames++;
    case (cur_op)
      8'h06: wel = 1'b1;
      8'h04: wel = 1'b0;
      8'h02, 8'h20, 8'hC7: if (wel) begin busy_left = POLLS; wel = 1'b0; end
      8'h05: if (busy_left > 0) busy_left--;
      default: ;
    endcase
    nbytes = 0;
  end

  always @(posedge clk) begin
    if (spi_cs_n) hi_run++;
    else hi_run = 0;
  end

  always @(negedge clk) begin
    if (rst_n && spi_cs_n && !spi_sclk) idle_viol++;
    if (rd_valid && rcount < 64) begin rbuf[rcount] = rd_data; rcount++; end
    if (done) ndone++;
  end

  // ---------------- request driver ----------------
  int fbase = 0, rbase = 0, pbase = 0, dbase = 0;
  task automatic run_req(input logic [2:0] op, input logic [23:0] a,
                         input logic [15:0] len, output logic got_err);
    int t;
    @(negedge clk);
    fbase = frames; rbase = rcount; pbase = pcount; dbase = ndone; wbase = takes;
    req_op = op; req_addr = a; req_len = len; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    got_err = 1'b0;
    t = 0;
    do begin
      @(negedge clk); t++;
      if (err) got_err = 1'b1;
    end while (!(done || err) && t < 40000);
    repeat (3) @(negedge clk);
  endtask

  // vector: op, addr, len, exp_err, exp_frames, main opcode, main frame bytes
  function automatic logic [71:0] vec(logic [2:0] op, logic [23:0] a, logic [15:0] len,
      logic e, logic [3:0] nf, logic [7:0] mop, logic [11:0] nb);
    return {4'b0, op, a, len, e, nf, mop, nb};
  endfunction

  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    vec(3'd0, 24'h0, 16'd0, 1'b0, 4'd1, 8'h06, 12'd1),      // R3
    vec(3'd1, 24'h0, 16'd0, 1'b0, 4'd1, 8'h04, 12'd1),      // R3
    vec(3'd2, 24'h0, 16'd0, 1'b0, 4'd1, 8'h05, 12'd2),      // R4
    vec(3'd3, 24'h1234F0, 16'd5, 1'b0, 4'd1, 8'h03, 12'd9), // R5
    vec(3'd3, 24'h00ABCD, 16'd0, 1'b0, 4'd1, 8'h03, 12'd4), // R5 zero length
    vec(3'd7, 24'h0, 16'd0, 1'b0, 4'd1, 8'h9F, 12'd4),      // R6
    vec(3'd4, 24'h001000, 16'd4, 1'b0, 4'd5, 8'h02, 12'd8), // R7 R9
    vec(3'd5, 24'h0AB000, 16'd0, 1'b0, 4'd5, 8'h20, 12'd4), // R8 R9
    vec(3'd6, 24'h0, 16'd0, 1'b0, 4'd5, 8'hC7, 12'd1),      // R8 R9
    vec(3'd4, 24'h002000, 16'd0, 1'b1, 4'd0, 8'h00, 12'd0)  // R11
  };

  initial begin
    logic ge;
    repeat (3) @(negedge clk);
    // R1 R12 reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R1", "sclk after reset", spi_sclk, 1);
    chk(req_ready && !done && !err && !rd_valid, "R12", "idle outputs after reset",
        {req_ready, done, err, rd_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready after reset release", req_ready, 1);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op; logic [23:0] a; logic [15:0] len; logic e;
      int nf, mop, nb, mi;
      op = VEC[v][67:65]; a = VEC[v][64:41]; len = VEC[v][40:25]; e = VEC[v][24];
      nf = int'(VEC[v][23:20]); mop = int'(VEC[v][19:12]); nb = int'(VEC[v][11:0]);
      run_req(op, a, len, ge);
      chk(ge == e, "R11", $sformatf("vec %0d err flag", v), ge, e);
      chk(frames - fbase == nf, "R9", $sformatf("vec %0d frame count", v), frames - fbase, nf);
      chk(ndone - dbase == (e ? 0 : 1), "R12", $sformatf("vec %0d done pulses", v),
          ndone - dbase, e ? 0 : 1);
      if (nf == 0) continue;
      mi = fbase + ((nf == 5) ? 1 : 0);
      chk(fr_op[mi] == 8'(mop), "R2", $sformatf("vec %0d opcode", v), fr_op[mi], mop);
      chk(fr_nb[mi] == nb, "R3", $sformatf("vec %0d frame bytes", v), fr_nb[mi], nb);
      if (nb >= 4) chk(fr_addr[mi] == a, "R5", $sformatf("vec %0d address", v), fr_addr[mi], a);
      if (nf == 5) begin
        chk(fr_op[fbase] == 8'h06, "R9", "write enable first", fr_op[fbase], 8'h06);
        chk(fr_op[fbase+2] == 8'h05 && fr_op[fbase+4] == 8'h05 && fr_nb[fbase+4] == 2,
            "R9", "status polls after command", fr_op[fbase+4], 8'h05);
      end
      if (op == 3'd3) begin
        chk(rcount - rbase == int'(len), "R5", "read byte count", rcount - rbase, len);
        for (int k = 0; k < int'(len); k++)
          chk(rbuf[rbase+k] == rpat(a + 24'(k)), "R5", "read data",
              rbuf[rbase+k], rpat(a + 24'(k)));
      end
      if (op == 3'd7) begin
        chk(rcount - rbase == 3, "R6", "id byte count", rcount - rbase, 3);
        for (int k = 0; k < 3; k++)
          chk(rbuf[rbase+k] == idb(k + 1), "R6", "id byte", rbuf[rbase+k], idb(k + 1));
      end
      if (op == 3'd2) begin
        chk(rcount - rbase == 1 && rbuf[rbase] == 8'h00, "R4", "status value after wrdi",
            rbuf[rbase], 0);
      end
      if (op == 3'd4) begin
        chk(pcount - pbase == int'(len), "R7", "program byte count", pcount - pbase, len);
        for (int k = 0; k < int'(len); k++)
          chk(pbuf[pbase+k] == wpat(k), "R7", "program data", pbuf[pbase+k], wpat(k));
      end
    end

    // R11 over-long program: no frame, no done
    run_req(3'd4, 24'h003000, 16'd257, ge);
    repeat (20) @(negedge clk);
    chk(ge == 1'b1, "R11", "len 257 rejected", ge, 1);
    chk(frames == fbase, "R11", "len 257 no frame", frames - fbase, 0);
    chk(ndone == dbase, "R11", "len 257 no done", ndone - dbase, 0);

    // R7 R9 R10 full page with a wider gap
    cfg_gap = 8'd12;
    run_req(3'd4, 24'h004000, 16'd256, ge);
    chk(ge == 1'b0 && frames - fbase == 5, "R9", "256-byte page frames", frames - fbase, 5);
    chk(fr_nb[fbase+1] == 260, "R7", "256-byte page frame bytes", fr_nb[fbase+1], 260);
    chk(pcount - pbase == 256, "R7", "256-byte page count", pcount - pbase, 256);
    begin
      int bad = 0;
      for (int k = 0; k < 256; k++) if (pbuf[pbase+k] != wpat(k)) bad++;
      chk(bad == 0, "R7", "256-byte page data mismatches", bad, 0);
    end
    for (int f = 1; f < 5; f++)
      chk(fr_gap[fbase+f] >= 12, "R10", $sformatf("gap before frame %0d", f),
          fr_gap[fbase+f], 12);

    // R10 zero gap still separates frames
    cfg_gap = 8'd0;
    run_req(3'd5, 24'h010000, 16'd0, ge);
    chk(fr_gap[fbase+1] >= 1 && frames - fbase == 5, "R10", "gap with cfg 0",
        fr_gap[fbase+1], 1);

    chk(mode_viol == 0, "R2", "sclk low at chip select fall", mode_viol, 0);
    chk(idle_viol == 0, "R1", "sclk low while deselected", idle_viol, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule